// File: doc/BRIEF.md
# Clock Domain Enable Generator

This block turns one base clock into a set of per-cycle enable strobes, one per derived clock domain, so that downstream logic runs on the base clock and qualifies its flops with a strobe rather than with a gated or divided clock. Six strobes come out: a system bus strobe, a core strobe, a copy of the core strobe that trails it by two cycles, and three peripheral strobes that are slower fractions of the bus strobe.

Software programs the block through a small write port. One register holds the per-domain stop bits. A second register holds three peripheral divide ratios and a core divide ratio, each stored as ratio minus one. The core ratio applies only while the self-test input is high; outside self-test the core strobe runs at bus rate. A flag reports when the second peripheral ratio does not evenly divide the first, which would break the rule that the second peripheral domain runs at a whole multiple of the first.

Every divider takes a new ratio only when its current period ends, so a reprogrammed ratio never yields a shortened period.

Top module: `clkdom_strobe_gen`

## Requirements
- R1: After synchronous reset both registers read zero. Every domain is then enabled at divide-by-1: bus, core and all peripheral strobes are high on every cycle, the trailing core strobe is low for the first two cycles, and `cfg_err` is low.
- R2: With `cfg_sel`=0, a write sets the stop bits. Bit 0 stops the core strobe, bit 1 stops the bus strobe, bit 2 stops peripheral 0, bit 3 stops peripheral 1 and bit 9 stops peripheral 2. A stopped strobe stays low.
- R3: While `selftest` is low and no longer period is still in progress, the core strobe equals the bus strobe on every cycle whenever neither is stopped.
- R4: While `selftest` is high, the core strobe fires once every N cycles, where N is the divider register field [14:12] plus one (1 to 8). The first core strobe after the core is started falls on the first enabled cycle.
- R5: `core_dly_en` equals `core_en` from two cycles earlier, so it has the same rate in every mode. It is forced low on any cycle on which the core stop bit is set.
- R6: Peripheral k fires once every M_k bus strobes. M_k is the divider register field [4k+3:4k] plus one (1 to 16), with k = 0, 1, 2.
- R7: A new core or peripheral ratio takes effect only after the current period of that domain has ended. No period shorter than the old or the new ratio appears.
- R8: While the bus strobe is stopped, all peripheral strobes are low. When the bus strobe is restarted, every running peripheral fires on the first bus strobe and counts its period from there.
- R9: `cfg_err` is high exactly when (field[3:0]+1) modulo (field[7:4]+1) is nonzero.
- R10: A write takes effect on the cycle after the clock edge that samples it. On a stop-bit write, data bits other than 0, 1, 2, 3 and 9 have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 1 | Register select: 0 stop bits, 1 divide ratios |
| cfg_wdata | input | 15 | Write data |
| selftest | input | 1 | Self-test mode: the core ratio is applied |
| bus_en | output | 1 | Bus domain strobe |
| core_en | output | 1 | Core domain strobe |
| core_dly_en | output | 1 | Core strobe delayed by two cycles |
| per_en | output | 3 | Peripheral domain strobes, bit k for peripheral k |
| cfg_err | output | 1 | Peripheral ratio rule violated |

## Verification
The bench reprograms a peripheral ratio in the middle of a long period. A design that reloads at once would emit a short period at that point. The bench toggles the bus stop bit while the dividers are part-way through a count. A block that keeps the old count instead of realigning would fire its first peripheral strobe late. The bench walks a single stop bit across all ten low positions, reserved ones included, which exposes a mis-wired or swapped stop bit. It also leaves self-test with an eight-cycle core period still in progress. The trailing core strobe is checked against the core strobe on every cycle, so a delay of one or three cycles, or a failure to stop with the core, shows up at once.

// File: rtl/clkdom_pkg.sv
package clkdom_pkg;

    localparam int NUM_PER   = 3;
    localparam int PER_DIV_W = 4;
    localparam int ST_DIV_W  = 3;
    localparam int CORE_LAG  = 2;

    // stop-bit positions inside a write of the stop register
    localparam int STOP_CORE_POS = 0;
    localparam int STOP_BUS_POS  = 1;
    localparam int STOP_PER_POS [NUM_PER] = '{2, 3, 9};

    typedef struct packed {
        logic [NUM_PER-1:0] per;
        logic               bus;
        logic               core;
    } stop_t;

    typedef struct packed {
        logic [ST_DIV_W-1:0]                 st_m1;
        logic [NUM_PER-1:0][PER_DIV_W-1:0]   per_m1;
    } div_cfg_t;

    localparam int CFG_W = $bits(div_cfg_t);

    typedef enum logic {
        SEL_STOP   = 1'b0,
        SEL_DIVIDE = 1'b1
    } cfg_sel_e;

    // true when ratio a (stored minus one) is not a whole multiple of ratio b
    function automatic logic ratio_mismatch(
        input logic [PER_DIV_W-1:0] a_m1,
        input logic [PER_DIV_W-1:0] b_m1
    );
        logic [PER_DIV_W:0] a;
        logic [PER_DIV_W:0] b;
        a = {1'b0, a_m1} + {{PER_DIV_W{1'b0}}, 1'b1};
        b = {1'b0, b_m1} + {{PER_DIV_W{1'b0}}, 1'b1};
        return (a % b) != '0;
    endfunction

endpackage

// File: rtl/clkdom_cfg_regs.sv
module clkdom_cfg_regs
    import clkdom_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic             sel,
    input  logic [CFG_W-1:0] wdata,
    output stop_t            stop_q,
    output div_cfg_t         div_q
);

    stop_t stop_wr;

    always_comb begin
        stop_wr.core = wdata[STOP_CORE_POS];
        stop_wr.bus  = wdata[STOP_BUS_POS];
        for (int k = 0; k < NUM_PER; k++) begin
            stop_wr.per[k] = wdata[STOP_PER_POS[k]];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stop_q <= '0;
            div_q  <= '0;
        end else if (we) begin
            if (cfg_sel_e'(sel) == SEL_STOP) begin
                stop_q <= stop_wr;
            end else begin
                div_q <= div_cfg_t'(wdata);
            end
        end
    end

endmodule

// File: rtl/clkdom_divider.sv
module clkdom_divider #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run,
    input  logic         tick,
    input  logic [W-1:0] ratio_m1,
    output logic         strobe
);

    logic [W-1:0] cnt_q;
    logic [W-1:0] act_q;

    assign strobe = run & tick & (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            act_q <= '0;
        end else if (!run) begin
            cnt_q <= '0;
            act_q <= ratio_m1;
        end else if (tick) begin
            if (cnt_q == act_q) begin
                cnt_q <= '0;
                act_q <= ratio_m1;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/clkdom_lag.sv
module clkdom_lag #(
    parameter int DEPTH = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);

    logic [DEPTH-1:0] sr_q;

    generate
        if (DEPTH == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) sr_q <= '0;
                else     sr_q <= din;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) sr_q <= '0;
                else     sr_q <= {sr_q[DEPTH-2:0], din};
            end
        end
    endgenerate

    assign dout = sr_q[DEPTH-1];

endmodule

// File: rtl/clkdom_strobe_gen.sv
module clkdom_strobe_gen
    import clkdom_pkg::*;
#(
    parameter int LAG = CORE_LAG
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_we,
    input  logic               cfg_sel,
    input  logic [CFG_W-1:0]   cfg_wdata,
    input  logic               selftest,
    output logic               bus_en,
    output logic               core_en,
    output logic               core_dly_en,
    output logic [NUM_PER-1:0] per_en,
    output logic               cfg_err
);

    stop_t    stop_q;
    div_cfg_t div_q;

    clkdom_cfg_regs i_regs (
        .clk    (clk),
        .rst    (rst),
        .we     (cfg_we),
        .sel    (cfg_sel),
        .wdata  (cfg_wdata),
        .stop_q (stop_q),
        .div_q  (div_q)
    );

    assign bus_en = ~stop_q.bus;

    // core: divided only in self-test, else bus rate and in phase
    logic [ST_DIV_W-1:0] core_ratio;
    assign core_ratio = selftest ? div_q.st_m1 : '0;

    clkdom_divider #(.W(ST_DIV_W)) i_core_div (
        .clk      (clk),
        .rst      (rst),
        .run      (~stop_q.core),
        .tick     (1'b1),
        .ratio_m1 (core_ratio),
        .strobe   (core_en)
    );

    logic core_lagged;

    clkdom_lag #(.DEPTH(LAG)) i_core_lag (
        .clk  (clk),
        .rst  (rst),
        .din  (core_en),
        .dout (core_lagged)
    );

    assign core_dly_en = core_lagged & ~stop_q.core;

    // peripherals: counted in bus strobes, held in reset while bus is stopped
    generate
        for (genvar k = 0; k < NUM_PER; k++) begin : g_per
            clkdom_divider #(.W(PER_DIV_W)) i_per_div (
                .clk      (clk),
                .rst      (rst),
                .run      (~stop_q.per[k] & bus_en),
                .tick     (bus_en),
                .ratio_m1 (div_q.per_m1[k]),
                .strobe   (per_en[k])
            );
        end
    endgenerate

    assign cfg_err = ratio_mismatch(div_q.per_m1[0], div_q.per_m1[1]);

endmodule

// File: rtl/clkdom_strobe_chk.sv
module clkdom_strobe_chk
    import clkdom_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input stop_t              stop_q,
    input div_cfg_t           div_q,
    input logic               bus_en,
    input logic               core_en,
    input logic               core_dly_en,
    input logic [NUM_PER-1:0] per_en,
    input logic               cfg_err
);

    a_r2_bus_stopped: assert property (@(posedge clk) disable iff (rst)
        stop_q.bus |-> !bus_en);

    a_r2_core_stopped: assert property (@(posedge clk) disable iff (rst)
        stop_q.core |-> !core_en);

    a_r5_lag_stopped: assert property (@(posedge clk) disable iff (rst)
        stop_q.core |-> !core_dly_en);

    a_r5_lag_follows: assert property (@(posedge clk) disable iff (rst)
        core_dly_en |-> $past(core_en, 2));

    a_r8_per_needs_bus: assert property (@(posedge clk) disable iff (rst)
        (per_en != '0) |-> bus_en);

    a_r9_unit_ratio_clean: assert property (@(posedge clk) disable iff (rst)
        (div_q.per_m1[1] == '0) |-> !cfg_err);

    generate
        for (genvar k = 0; k < NUM_PER; k++) begin : g_per_chk
            a_r2_per_stopped: assert property (@(posedge clk) disable iff (rst)
                stop_q.per[k] |-> !per_en[k]);
        end
    endgenerate

endmodule

bind clkdom_strobe_gen clkdom_strobe_chk i_chk (
    .clk         (clk),
    .rst         (rst),
    .stop_q      (stop_q),
    .div_q       (div_q),
    .bus_en      (bus_en),
    .core_en     (core_en),
    .core_dly_en (core_dly_en),
    .per_en      (per_en),
    .cfg_err     (cfg_err)
);

// File: tb/test_clkdom_strobe_gen.sv
`timescale 1ns/1ps
module test_clkdom_strobe_gen;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic        cfg_sel = 1'b0;
    logic [14:0] cfg_wdata = '0;
    logic        selftest = 1'b0;
    logic        bus_en, core_en, core_dly_en, cfg_err;
    logic [2:0]  per_en;

    clkdom_strobe_gen i_clkdom_strobe_gen (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .selftest(selftest), .bus_en(bus_en),
        .core_en(core_en), .core_dly_en(core_dly_en), .per_en(per_en),
        .cfg_err(cfg_err)
    );

    always #2 clk = ~clk;

    int    vectors = 0;
    int    fails = 0;
    bit    done = 1'b0;
    string phase = "";

    // behavioural reference state
    int m_stop = 0;
    int m_st = 0;
    int m_per [3] = '{0, 0, 0};
    int c_cnt = 0, c_act = 0;
    int p_cnt [3] = '{0, 0, 0};
    int p_act [3] = '{0, 0, 0};
    bit m_d1 = 0, m_d2 = 0;
    int pbit [3] = '{2, 3, 9};

    function automatic bit stopped(int b);
        return ((m_stop >> b) & 1) != 0;
    endfunction
    function automatic bit e_bus();
        return !stopped(1);
    endfunction
    function automatic bit e_core();
        return !stopped(0) && c_cnt == 0;
    endfunction
    function automatic bit e_per(int k);
        return !stopped(pbit[k]) && e_bus() && p_cnt[k] == 0;
    endfunction
    function automatic bit e_err();
        return ((m_per[0] + 1) % (m_per[1] + 1)) != 0;
    endfunction

    task automatic model_edge();
        if (rst) begin
            m_stop = 0; m_st = 0; c_cnt = 0; c_act = 0; m_d1 = 0; m_d2 = 0;
            for (int k = 0; k < 3; k++) begin
                m_per[k] = 0; p_cnt[k] = 0; p_act[k] = 0;
            end
        end else begin
            bit cs, bs;
            int ratio;
            cs = e_core();
            bs = e_bus();
            m_d2 = m_d1;
            m_d1 = cs;
            ratio = selftest ? m_st : 0;
            if (stopped(0)) begin
                c_cnt = 0; c_act = ratio;
            end else if (c_cnt == c_act) begin
                c_cnt = 0; c_act = ratio;
            end else begin
                c_cnt++;
            end
            for (int k = 0; k < 3; k++) begin
                if (stopped(pbit[k]) || !bs) begin
                    p_cnt[k] = 0; p_act[k] = m_per[k];
                end else if (p_cnt[k] == p_act[k]) begin
                    p_cnt[k] = 0; p_act[k] = m_per[k];
                end else begin
                    p_cnt[k]++;
                end
            end
            if (cfg_we) begin
                if (!cfg_sel) begin
                    m_stop = int'(cfg_wdata) & 32'h3FF;
                end else begin
                    for (int k = 0; k < 3; k++) m_per[k] = (int'(cfg_wdata) >> (4 * k)) & 15;
                    m_st = (int'(cfg_wdata) >> 12) & 7;
                end
            end
        end
    endtask

    task automatic chk(string req, logic act, bit exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s [%s] t=%0t actual=%b expected=%b", req, phase, $time, act, exp);
        end
    endtask

    task automatic compare();
        chk("R2 bus", bus_en, e_bus());
        chk(selftest ? "R4 core" : "R3 core", core_en, e_core());
        chk("R5 core_dly", core_dly_en, m_d2 && !stopped(0));
        for (int k = 0; k < 3; k++)
            chk(e_bus() ? "R6 per" : "R8 per", per_en[k], e_per(k));
        chk("R9 cfg_err", cfg_err, e_err());
    endtask

    task automatic cyc(int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            model_edge();
            @(negedge clk);
            compare();
        end
    endtask

    task automatic wr(bit sel, logic [14:0] data);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
        cyc(1);
        cfg_we = 1'b0;
    endtask

    initial begin
        phase = "R1 reset";
        cyc(3);
        rst = 1'b0;
        chk("R1 bus after reset", bus_en, 1'b1);
        chk("R1 err after reset", cfg_err, 1'b0);
        cyc(6);
        chk("R1 per all running", per_en[0] & per_en[1] & per_en[2], 1'b1);

        phase = "R6 peripheral ratios";
        wr(1'b1, 15'h0F13);
        cyc(40);

        phase = "R9 mismatch";
        wr(1'b1, 15'h0F23);
        cyc(10);
        wr(1'b1, 15'h0F33);
        cyc(10);

        phase = "R7 mid-period change";
        wr(1'b1, 15'h0F17);
        cyc(3);
        wr(1'b1, 15'h0F11);
        cyc(30);

        phase = "R4 self-test divide";
        selftest = 1'b1;
        wr(1'b1, 15'h4F11);
        cyc(30);
        wr(1'b1, 15'h7F11);
        cyc(40);

        phase = "R5 lag with core stop";
        wr(1'b0, 15'h0001);
        cyc(6);
        wr(1'b0, 15'h0000);
        cyc(20);

        phase = "R2 stop walk";
        for (int b = 0; b < 10; b++) begin
            wr(1'b0, 15'(1 << b));
            cyc(20);
            wr(1'b0, 15'h0000);
            cyc(3);
        end

        phase = "R8 bus stop and restart";
        wr(1'b1, 15'h7537);
        cyc(5);
        wr(1'b0, 15'h0002);
        cyc(7);
        wr(1'b0, 15'h0000);
        cyc(40);

        phase = "R3 leave self-test";
        cyc(3);
        selftest = 1'b0;
        cyc(20);

        phase = "R10 reserved stop bits";
        wr(1'b0, 15'h7DF0);
        cyc(20);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog [%s] t=%0t actual=hung expected=done", phase, $time);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

endmodule